// File: doc/BRIEF.md
# Pipeline Exception Capture Unit

This unit sits beside the decode and execute stages of a five-stage in-order pipeline. It watches two fault sources: an unknown-opcode flag raised by the instruction currently in decode, and an arithmetic-overflow flag raised by the instruction currently in execute. Each flag arrives with the address of its instruction. In the cycle a fault is accepted, the unit raises a take pulse, clears the control fields of the pipeline registers that hold the faulting instruction and everything younger, and presents the handler address for the fetch stage to load. In the same way as a mispredicted-branch flush, the pipeline zeroes the flagged registers on the same clock edge.

On that edge the unit also records the return address (faulting address plus one instruction width) and a one-bit reason code in two state registers, which software can read through plain read pins. Where the handler lives is set by a static mode pin. In fixed mode every fault goes to one common entry. In vectored mode each reason has its own entry, and the entries are one stride apart above a base. When both stages fault together, the instruction further along the pipeline is older and therefore wins. This keeps faults precise. A flag belonging to an instruction that the pipeline is already squashing for another reason, such as a taken branch, is ignored.

The interface carries no data stream, so no pin has valid/ready or back-pressure. The fault flags are single-cycle qualifiers that the pipeline samples in the same cycle, and the unit can never refuse one.

Top module: `exc_capture_unit`

## Requirements
- R1: While reset is held, `epc_rd` reads 0 and `cause_rd` reads 0, and `exc_take` is low while no flag is raised.
- R2: A live unknown-opcode flag alone (`id_undef`=1, `id_kill`=0, no live overflow) raises `exc_take` in the same cycle. After the next rising edge, `cause_rd` reads 0 and `epc_rd` reads `id_pc`+4, computed modulo 2^32.
- R3: A live overflow flag (`ex_ovf`=1, `ex_kill`=0) raises `exc_take` in the same cycle. After the next rising edge, `cause_rd` reads 1 and `epc_rd` reads `ex_pc`+4.
- R4: With `vec_mode`=0, `handler_pc` is 0x80000180 in every cycle where `exc_take` is high, whatever the reason.
- R5: With `vec_mode`=1, `handler_pc` is 0xC0000000 for reason 0 (unknown opcode) and 0xC0000020 for reason 1 (overflow), so entries are 0x20 apart.
- R6: A taken overflow asserts `flush_ifid`, `flush_idex` and `flush_exmem` together, so the faulting instruction never writes its destination.
- R7: A taken unknown-opcode fault asserts `flush_ifid` and `flush_idex` but leaves `flush_exmem` low, so the older instruction in execute completes.
- R8: When both flags are live in the same cycle, the overflow is taken: reason 1, return address from `ex_pc`, all three flushes, and the handler for reason 1.
- R9: In any cycle without `exc_take`, `epc_rd` and `cause_rd` keep their values across the edge.
- R10: A flag whose kill input is high is discarded. It causes no take, no flush and no state change, and a live flag in the other stage is still taken.
- R11: When `exc_take` is low, all three flush outputs are low and `handler_pc` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| vec_mode | input | 1 | 0: common handler entry, 1: per-reason entries |
| id_undef | input | 1 | Decode-stage instruction has an unknown opcode |
| id_kill | input | 1 | Decode-stage instruction is being squashed by other logic |
| id_pc | input | 32 | Address of the decode-stage instruction |
| ex_ovf | input | 1 | Execute-stage instruction overflowed |
| ex_kill | input | 1 | Execute-stage instruction is being squashed by other logic |
| ex_pc | input | 32 | Address of the execute-stage instruction |
| exc_take | output | 1 | A fault is accepted this cycle |
| handler_pc | output | 32 | Next fetch address while `exc_take` is high, else 0 |
| flush_ifid | output | 1 | Clear the fetch/decode register control fields |
| flush_idex | output | 1 | Clear the decode/execute register control fields |
| flush_exmem | output | 1 | Clear the execute/memory register control fields |
| epc_rd | output | 32 | Saved return address |
| cause_rd | output | 1 | Saved reason: 0 unknown opcode, 1 overflow |

## Verification
The two functions that can land in the same cycle are the decode-stage unknown-opcode capture and the execute-stage overflow capture. The bench drives both flags in one cycle, with distinct addresses on `id_pc` and `ex_pc`, in both handler modes. It judges the result by the recorded address and reason, the handler address and the flush pattern. The overflow's address and the full three-register flush must appear. It also pairs a killed overflow with a live unknown opcode, to show that the arbitration only considers live flags.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [0:0] {
    CAUSE_UNDEF = 1'b0,
    CAUSE_OVF   = 1'b1
  } exc_cause_e;

  // Sources are indexed by age: index 0 is the oldest (execute stage).
  localparam int SRC_EX = 0;
  localparam int SRC_ID = 1;

  function automatic exc_cause_e src_cause(input int src);
    return (src == SRC_EX) ? CAUSE_OVF : CAUSE_UNDEF;
  endfunction
endpackage

// File: rtl/exc_arbiter.sv
// Oldest-first selection among fault sources, plus the flush mask.
// Pipeline register j holds the instruction that source j sits in;
// register NSRC is the youngest (fetch/decode). A winner at index w
// clears register w and all younger ones.
module exc_arbiter #(
  parameter int NSRC = 2,
  parameter int XLEN = 32,
  localparam int IW   = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int NREG = NSRC + 1
) (
  input  logic [NSRC-1:0]           raise,
  input  logic [NSRC-1:0]           kill,
  input  logic [NSRC-1:0][XLEN-1:0] pc,
  output logic                      take,
  output logic [IW-1:0]             win,
  output logic [XLEN-1:0]           win_pc,
  output logic [NREG-1:0]           flush
);
  logic [NSRC-1:0] live;

  assign live = raise & ~kill;
  assign take = |live;

  always_comb begin
    win = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (live[i]) win = IW'(i);
    end
  end

  assign win_pc = pc[win];

  generate
    for (genvar j = 0; j < NREG; j++) begin : g_flush
      assign flush[j] = take && (int'(win) <= j);
    end
  endgenerate
endmodule

// File: rtl/exc_vector.sv
// Handler address: one common entry, or base + reason * stride.
module exc_vector #(
  parameter int              XLEN      = 32,
  parameter logic [XLEN-1:0] FIXED_ENT = 32'h8000_0180,
  parameter logic [XLEN-1:0] VEC_BASE  = 32'hC000_0000,
  parameter logic [XLEN-1:0] VEC_STEP  = 32'h0000_0020
) (
  input  logic                  take,
  input  logic                  vec_mode,
  input  exc_pkg::exc_cause_e   cause,
  output logic [XLEN-1:0]       target
);
  logic [XLEN-1:0] vec_addr;

  assign vec_addr = VEC_BASE + (VEC_STEP * XLEN'(cause));

  always_comb begin
    if (!take)        target = '0;
    else if (vec_mode) target = vec_addr;
    else              target = FIXED_ENT;
  end
endmodule

// File: rtl/exc_state.sv
// Return-address and reason registers, written only on a taken fault.
module exc_state #(
  parameter int XLEN       = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                take,
  input  logic [XLEN-1:0]     fault_pc,
  input  exc_pkg::exc_cause_e cause_in,
  output logic [XLEN-1:0]     epc_q,
  output exc_pkg::exc_cause_e cause_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epc_q   <= '0;
      cause_q <= exc_pkg::CAUSE_UNDEF;
    end else if (take) begin
      epc_q   <= fault_pc + XLEN'(INSN_BYTES);
      cause_q <= cause_in;
    end
  end
endmodule

// File: rtl/exc_capture_unit.sv
module exc_capture_unit #(
  parameter int              XLEN       = 32,
  parameter int              INSN_BYTES = 4,
  parameter logic [XLEN-1:0] FIXED_ENT  = 32'h8000_0180,
  parameter logic [XLEN-1:0] VEC_BASE   = 32'hC000_0000,
  parameter logic [XLEN-1:0] VEC_STEP   = 32'h0000_0020
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            vec_mode,
  input  logic            id_undef,
  input  logic            id_kill,
  input  logic [XLEN-1:0] id_pc,
  input  logic            ex_ovf,
  input  logic            ex_kill,
  input  logic [XLEN-1:0] ex_pc,
  output logic            exc_take,
  output logic [XLEN-1:0] handler_pc,
  output logic            flush_ifid,
  output logic            flush_idex,
  output logic            flush_exmem,
  output logic [XLEN-1:0] epc_rd,
  output logic            cause_rd
);
  import exc_pkg::*;

  localparam int NSRC = 2;
  localparam int IW   = $clog2(NSRC);

  logic [NSRC-1:0]           src_raise;
  logic [NSRC-1:0]           src_kill;
  logic [NSRC-1:0][XLEN-1:0] src_pc;
  logic [IW-1:0]             win;
  logic [XLEN-1:0]           win_pc;
  logic [NSRC:0]             flush;
  exc_cause_e                win_cause;
  exc_cause_e                cause_q;

  assign src_raise[SRC_EX] = ex_ovf;
  assign src_kill[SRC_EX]  = ex_kill;
  assign src_pc[SRC_EX]    = ex_pc;
  assign src_raise[SRC_ID] = id_undef;
  assign src_kill[SRC_ID]  = id_kill;
  assign src_pc[SRC_ID]    = id_pc;

  exc_arbiter #(.NSRC(NSRC), .XLEN(XLEN)) arb_i (
    .raise  (src_raise),
    .kill   (src_kill),
    .pc     (src_pc),
    .take   (exc_take),
    .win    (win),
    .win_pc (win_pc),
    .flush  (flush)
  );

  assign win_cause = src_cause(int'(win));

  exc_vector #(
    .XLEN(XLEN), .FIXED_ENT(FIXED_ENT), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
  ) vec_i (
    .take     (exc_take),
    .vec_mode (vec_mode),
    .cause    (win_cause),
    .target   (handler_pc)
  );

  exc_state #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) st_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (exc_take),
    .fault_pc (win_pc),
    .cause_in (win_cause),
    .epc_q    (epc_rd),
    .cause_q  (cause_q)
  );

  assign cause_rd    = cause_q;
  assign flush_exmem = flush[0];
  assign flush_idex  = flush[1];
  assign flush_ifid  = flush[2];
endmodule

// File: rtl/exc_capture_chk.sv
module exc_capture_chk #(
  parameter int              XLEN      = 32,
  parameter logic [XLEN-1:0] FIXED_ENT = 32'h8000_0180,
  parameter logic [XLEN-1:0] VEC_BASE  = 32'hC000_0000,
  parameter logic [XLEN-1:0] VEC_STEP  = 32'h0000_0020
) (
  input logic            clk,
  input logic            rst_n,
  input logic            vec_mode,
  input logic            id_undef,
  input logic            id_kill,
  input logic [XLEN-1:0] id_pc,
  input logic            ex_ovf,
  input logic            ex_kill,
  input logic [XLEN-1:0] ex_pc,
  input logic            exc_take,
  input logic [XLEN-1:0] handler_pc,
  input logic            flush_ifid,
  input logic            flush_idex,
  input logic            flush_exmem,
  input logic [XLEN-1:0] epc_rd,
  input logic            cause_rd
);
  logic ex_live, id_live;
  assign ex_live = ex_ovf && !ex_kill;
  assign id_live = id_undef && !id_kill;

  AST_OVF_FLUSHES_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    ex_live |-> exc_take && flush_ifid && flush_idex && flush_exmem); // R6

  AST_UNDEF_KEEPS_EX: assert property (@(posedge clk) disable iff (!rst_n)
    (id_live && !ex_live) |-> exc_take && flush_ifid && flush_idex && !flush_exmem); // R7

  AST_OLDEST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> cause_rd == $past(ex_live)); // R8

  AST_EPC_FROM_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> epc_rd == $past((ex_live ? ex_pc : id_pc) + XLEN'(4))); // R2

  AST_STATE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_take |=> $stable(epc_rd) && $stable(cause_rd)); // R9

  AST_KILLED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ex_live && !id_live) |-> !exc_take); // R10

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_take |-> handler_pc == '0 && !flush_ifid && !flush_idex && !flush_exmem); // R11

  AST_FIXED_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_take && !vec_mode) |-> handler_pc == FIXED_ENT); // R4

  AST_VEC_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_take && vec_mode) |-> handler_pc == (ex_live ? VEC_BASE + VEC_STEP : VEC_BASE)); // R5
endmodule

bind exc_capture_unit exc_capture_chk #(
  .XLEN(XLEN), .FIXED_ENT(FIXED_ENT), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
) chk_i (
  .clk(clk), .rst_n(rst_n), .vec_mode(vec_mode),
  .id_undef(id_undef), .id_kill(id_kill), .id_pc(id_pc),
  .ex_ovf(ex_ovf), .ex_kill(ex_kill), .ex_pc(ex_pc),
  .exc_take(exc_take), .handler_pc(handler_pc),
  .flush_ifid(flush_ifid), .flush_idex(flush_idex), .flush_exmem(flush_exmem),
  .epc_rd(epc_rd), .cause_rd(cause_rd)
);

// File: tb/exc_capture_unit_tb_top.sv
module exc_capture_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vec_mode = 1'b0;
  logic        id_undef = 1'b0, id_kill = 1'b0, ex_ovf = 1'b0, ex_kill = 1'b0;
  logic [31:0] id_pc = '0, ex_pc = '0;
  logic        exc_take, flush_ifid, flush_idex, flush_exmem, cause_rd;
  logic [31:0] handler_pc, epc_rd;

  always #5 clk = ~clk;

  exc_capture_unit dut_i (
    .clk(clk), .rst_n(rst_n), .vec_mode(vec_mode),
    .id_undef(id_undef), .id_kill(id_kill), .id_pc(id_pc),
    .ex_ovf(ex_ovf), .ex_kill(ex_kill), .ex_pc(ex_pc),
    .exc_take(exc_take), .handler_pc(handler_pc),
    .flush_ifid(flush_ifid), .flush_idex(flush_idex), .flush_exmem(flush_exmem),
    .epc_rd(epc_rd), .cause_rd(cause_rd)
  );

  typedef struct {
    logic        take;
    logic [31:0] hpc;
    logic [2:0]  fl;     // {ifid, idex, exmem}
    logic [31:0] epc;
    logic        cause;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  int          n_run = 0, n_fail = 0;
  logic [31:0] mdl_epc = '0;
  logic        mdl_cause = 1'b0;
  bit          done = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes the expected result.
  task automatic drive(input logic vm, input logic und, input logic idk, input logic [31:0] ipc,
                       input logic ovf, input logic exk, input logic [31:0] epc_in, input string tag);
    exp_t e;
    logic lex, lid;
    @(negedge clk);
    vec_mode = vm; id_undef = und; id_kill = idk; id_pc = ipc;
    ex_ovf = ovf; ex_kill = exk; ex_pc = epc_in;
    lex = ovf && !exk;
    lid = und && !idk;
    e.take = lex || lid;
    e.fl   = lex ? 3'b111 : (lid ? 3'b110 : 3'b000);
    if (e.take) begin
      mdl_cause = lex;
      mdl_epc   = (lex ? epc_in : ipc) + 32'd4;
      e.hpc = !vm ? 32'h8000_0180 : (lex ? 32'hC000_0020 : 32'hC000_0000);
    end else begin
      e.hpc = 32'h0;
    end
    e.epc = mdl_epc;
    e.cause = mdl_cause;
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  // Monitor: one edge after each drive, combinational outputs still reflect
  // the driven inputs and the state registers show the update of that edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check({e.tag, " take"},   {31'b0, exc_take}, {31'b0, e.take});
        check({e.tag, " target"}, handler_pc, e.hpc);
        check({e.tag, " flush"},  {29'b0, flush_ifid, flush_idex, flush_exmem}, {29'b0, e.fl});
        check({e.tag, " epc"},    epc_rd, e.epc);
        check({e.tag, " cause"},  {31'b0, cause_rd}, {31'b0, e.cause});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset epc", epc_rd, 32'h0);
    check("R1 reset cause", {31'b0, cause_rd}, 32'h0);
    check("R1 reset take", {31'b0, exc_take}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    drive(0, 0, 0, 32'h0,        0, 0, 32'h0,   "R11 idle");
    drive(0, 1, 0, 32'h100,      0, 0, 32'h0FC, "R2 R4 R7 undef fixed");
    drive(0, 0, 0, 32'h0,        0, 0, 32'h0,   "R9 hold after undef");
    drive(0, 0, 0, 32'h204,      1, 0, 32'h200, "R3 R4 R6 ovf fixed");
    drive(0, 0, 0, 32'h0,        0, 0, 32'h0,   "R9 hold after ovf");
    drive(1, 1, 0, 32'h300,      0, 0, 32'h2FC, "R5 R7 undef vectored");
    drive(1, 0, 0, 32'h404,      1, 0, 32'h400, "R5 R6 ovf vectored");
    drive(1, 1, 0, 32'h504,      1, 0, 32'h500, "R8 both vectored");
    drive(0, 1, 0, 32'h604,      1, 0, 32'h600, "R8 both fixed");
    drive(0, 1, 1, 32'h700,      0, 0, 32'h0,   "R10 undef killed");
    drive(1, 1, 0, 32'h804,      1, 1, 32'h800, "R10 ovf killed undef live");
    drive(0, 0, 0, 32'h0,        1, 1, 32'h900, "R10 ovf killed alone");
    drive(1, 1, 1, 32'hA04,      1, 1, 32'hA00, "R10 both killed");
    drive(0, 1, 0, 32'hFFFF_FFFC, 0, 0, 32'h0,  "R2 epc wrap");
    drive(0, 0, 0, 32'h0,        0, 0, 32'h0,   "R9 R11 final idle");

    @(negedge clk);
    id_undef = 0; ex_ovf = 0;
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule